// File: doc/BRIEF.md
# Decoder Error Check and Dispatcher

This block sits beside a video decoding pipeline and watches six kinds of error evidence: an 8x8 block that claims too many coefficients, a bit pointer that runs past the position of the next start code, a decoded syntax element outside its legal range, a motion vector outside its legal range, a slice that ends without properly completed trailing bits, and a jump in the frame number sequence. Each check can be switched off by firmware and is mapped by firmware to one of three severity levels.

Every error that fires sets a sticky flag and raises the interrupt line. The highest severity seen in a cycle selects a command to the pipeline: carry on with a substituted default value (level 1), stop and resynchronize at the next slice (level 2), or drop pictures and resynchronize at the next I-frame or group of pictures (level 3). A level 2 or 3 command is held until firmware acknowledges it. All inputs are per-cycle strobes and levels with no back-pressure; the command output is a registered level that the pipeline reads every cycle.

Top module: `vdec_err_dispatch`

## Requirements
- R1: When `coef_vld` is high and `coef_cnt` is greater than 64, check 0 fires; a count of exactly 64 does not fire.
- R2: When `bit_vld` is high and `bit_pos` is strictly greater than `sc_pos`, check 1 fires; equal positions do not fire.
- R3: When `syn_vld` is high, `syn_val` is compared as a signed number with `syn_min` and `syn_max`; outside that range check 2 fires if `syn_is_mv` is low and check 3 fires if it is high.
- R4: When `slice_end` is high and `trail_ok` is low, check 4 fires.
- R5: On `frm_vld`, check 5 fires if `frm_num` is not the previous frame number plus one modulo 256; the first frame after reset never fires, and the previous number is updated on every `frm_vld`.
- R6: Check i is gated by `chk_en[i]`; a disabled check sets no flag and changes neither `err_sev` nor `pipe_cmd`.
- R7: Flag bit i of `err_flags` is set one cycle after check i fires and stays set until a cycle with `flag_clr[i]` high; a new error in the clear cycle wins. `err_irq` is high whenever any flag is set.
- R8: Check i takes its severity from `chk_sev[2i+1:2i]` (1, 2 or 3; code 0 counts as 1). `err_sev` shows, one cycle later, the highest severity among the checks that fired in the sampled cycle, and 0 if none fired.
- R9: `pipe_cmd` codes: 0 run, 1 substitute default and continue, 2 stop and resync at next slice, 3 resync at next I-frame. The command follows the highest severity of the cycle; a code 1 lasts one cycle only.
- R10: Code 2 or 3 is held until `fw_ack`; while held it is raised from 2 to 3 by a level 3 error but never lowered. In the acknowledge cycle the command becomes the severity of that cycle's errors, or 0.
- R11: `fw_ack` while no command is held has no effect on `pipe_cmd` or `err_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chk_en | input | 6 | Per-check enable |
| chk_sev | input | 12 | Two-bit severity per check |
| coef_vld | input | 1 | Coefficient count strobe |
| coef_cnt | input | 7 | Coefficients decoded for one 8x8 block |
| syn_vld | input | 1 | Syntax element strobe |
| syn_is_mv | input | 1 | Element is a motion vector component |
| syn_val | input | 16 | Decoded value, signed |
| syn_min | input | 16 | Lowest legal value, signed |
| syn_max | input | 16 | Highest legal value, signed |
| bit_vld | input | 1 | Bit position strobe |
| bit_pos | input | 24 | Bits consumed |
| sc_pos | input | 24 | Position of next start code |
| slice_end | input | 1 | Slice end strobe |
| trail_ok | input | 1 | Trailing bits complete |
| frm_vld | input | 1 | Frame number strobe |
| frm_num | input | 8 | Frame number |
| flag_clr | input | 6 | Write-one-to-clear for flags |
| fw_ack | input | 1 | Firmware acknowledge of a held command |
| err_flags | output | 6 | Sticky error flags |
| err_irq | output | 1 | Interrupt, any flag set |
| err_sev | output | 2 | Highest severity of last sampled cycle |
| pipe_cmd | output | 2 | Command to the pipeline |

## Verification
Every output is due exactly one clock edge after the inputs that cause it are sampled: flags, interrupt, severity and command all come from one register stage. The driver applies each vector just after a falling edge and pushes the expected outputs into a queue; the monitor pops one entry a short delay after each rising edge, so each comparison sees the result of the vector applied half a cycle earlier. Held commands, upgrades and acknowledges are checked by running several vectors in a row against the queued expectations.

// File: rtl/vdec_err_pkg.sv
package vdec_err_pkg;
  localparam int NCHK = 6;
  localparam int CK_COEF  = 0;
  localparam int CK_OVRN  = 1;
  localparam int CK_SYN   = 2;
  localparam int CK_MV    = 3;
  localparam int CK_TRAIL = 4;
  localparam int CK_FGAP  = 5;

  typedef logic [1:0] sev_t;

  localparam sev_t ACT_RUN    = 2'd0;
  localparam sev_t ACT_SUBST  = 2'd1;
  localparam sev_t ACT_RSLICE = 2'd2;
  localparam sev_t ACT_RIFRM  = 2'd3;

  function automatic sev_t norm_sev(input logic [1:0] code);
    return (code == 2'd0) ? 2'd1 : code;
  endfunction
endpackage

// File: rtl/vdec_err_checks.sv
module vdec_err_checks
  import vdec_err_pkg::*;
#(
  parameter int CW   = 7,
  parameter int MAXC = 64,
  parameter int SW   = 16,
  parameter int PW   = 24,
  parameter int FW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCHK-1:0]      en,
  input  logic                 coef_vld,
  input  logic [CW-1:0]        coef_cnt,
  input  logic                 syn_vld,
  input  logic                 syn_is_mv,
  input  logic signed [SW-1:0] syn_val,
  input  logic signed [SW-1:0] syn_min,
  input  logic signed [SW-1:0] syn_max,
  input  logic                 bit_vld,
  input  logic [PW-1:0]        bit_pos,
  input  logic [PW-1:0]        sc_pos,
  input  logic                 slice_end,
  input  logic                 trail_ok,
  input  logic                 frm_vld,
  input  logic [FW-1:0]        frm_num,
  output logic [NCHK-1:0]      hit
);
  logic [FW-1:0]   prev_q;
  logic            seen_q;
  logic            out_of_range;
  logic [NCHK-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (frm_vld) begin
      prev_q <= frm_num;
      seen_q <= 1'b1;
    end
  end

  assign out_of_range = (syn_val < syn_min) || (syn_val > syn_max);

  always_comb begin
    raw           = '0;
    raw[CK_COEF]  = coef_vld && (coef_cnt > CW'(MAXC));
    raw[CK_OVRN]  = bit_vld && (bit_pos > sc_pos);
    raw[CK_SYN]   = syn_vld && !syn_is_mv && out_of_range;
    raw[CK_MV]    = syn_vld && syn_is_mv && out_of_range;
    raw[CK_TRAIL] = slice_end && !trail_ok;
    raw[CK_FGAP]  = frm_vld && seen_q && (frm_num != FW'(prev_q + 1'b1));
  end

  assign hit = raw & en;

  // R1: a block at or below the coefficient limit never fires
  a_r1_coef_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_vld && coef_cnt <= CW'(MAXC)) |-> !hit[CK_COEF]);
  // R5: nothing is compared before the first frame number arrives
  a_r5_first_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !hit[CK_FGAP]);
endmodule

// File: rtl/vdec_err_sevmap.sv
module vdec_err_sevmap
  import vdec_err_pkg::*;
(
  input  logic [NCHK-1:0]   hit,
  input  logic [2*NCHK-1:0] cfg,
  output sev_t              top_sev
);
  sev_t lvl [NCHK];

  for (genvar i = 0; i < NCHK; i++) begin : g_lvl
    assign lvl[i] = hit[i] ? norm_sev(cfg[2*i +: 2]) : 2'd0;
  end

  always_comb begin
    top_sev = 2'd0;
    for (int i = 0; i < NCHK; i++) begin
      if (lvl[i] > top_sev) top_sev = lvl[i];
    end
  end
endmodule

// File: rtl/vdec_err_flags.sv
module vdec_err_flags
  import vdec_err_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCHK-1:0] hit,
  input  logic [NCHK-1:0] clr,
  output logic [NCHK-1:0] flags,
  output logic            irq
);
  logic [NCHK-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr) | hit;
  end

  assign flags = flags_q;
  assign irq   = |flags_q;

  // R7: a flag only drops after a clear request
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_q) & ~$past(clr) & ~flags_q) == '0));
  // R7: any error raises the interrupt next cycle
  a_r7_irq_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> irq);
endmodule

// File: rtl/vdec_err_ctrl.sv
module vdec_err_ctrl
  import vdec_err_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sev_t hit_sev,
  input  logic ack,
  output sev_t cmd,
  output sev_t sev
);
  sev_t cmd_q, sev_q, base, nxt;
  logic keep;

  assign keep = (cmd_q >= ACT_RSLICE) && !ack;
  assign base = keep ? cmd_q : ACT_RUN;
  assign nxt  = (hit_sev > base) ? hit_sev : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= ACT_RUN;
      sev_q <= 2'd0;
    end else begin
      cmd_q <= nxt;
      sev_q <= hit_sev;
    end
  end

  assign cmd = cmd_q;
  assign sev = sev_q;

  // R10: a held stop stays a stop until acknowledged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[1] && !ack) |=> cmd_q[1]);
  // R10: a held command is never lowered
  a_r10_no_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[1] && !ack) |=> (cmd_q >= $past(cmd_q)));
  // R9: substitution lasts a single cycle
  a_r9_subst_once: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == ACT_SUBST && hit_sev == 2'd0) |=> (cmd_q == ACT_RUN));
  // R11: acknowledge with nothing held leaves the pipeline running
  a_r11_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_q[1] && ack && hit_sev == 2'd0) |=> (cmd_q == ACT_RUN));
endmodule

// File: rtl/vdec_err_dispatch.sv
module vdec_err_dispatch
  import vdec_err_pkg::*;
#(
  parameter int CW   = 7,
  parameter int MAXC = 64,
  parameter int SW   = 16,
  parameter int PW   = 24,
  parameter int FW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [5:0]           chk_en,
  input  logic [11:0]          chk_sev,
  input  logic                 coef_vld,
  input  logic [CW-1:0]        coef_cnt,
  input  logic                 syn_vld,
  input  logic                 syn_is_mv,
  input  logic signed [SW-1:0] syn_val,
  input  logic signed [SW-1:0] syn_min,
  input  logic signed [SW-1:0] syn_max,
  input  logic                 bit_vld,
  input  logic [PW-1:0]        bit_pos,
  input  logic [PW-1:0]        sc_pos,
  input  logic                 slice_end,
  input  logic                 trail_ok,
  input  logic                 frm_vld,
  input  logic [FW-1:0]        frm_num,
  input  logic [5:0]           flag_clr,
  input  logic                 fw_ack,
  output logic [5:0]           err_flags,
  output logic                 err_irq,
  output logic [1:0]           err_sev,
  output logic [1:0]           pipe_cmd
);
  logic [NCHK-1:0] hit;
  sev_t            hit_sev;

  vdec_err_checks #(.CW(CW), .MAXC(MAXC), .SW(SW), .PW(PW), .FW(FW)) u_checks (
    .clk(clk), .rst_n(rst_n), .en(chk_en),
    .coef_vld(coef_vld), .coef_cnt(coef_cnt),
    .syn_vld(syn_vld), .syn_is_mv(syn_is_mv), .syn_val(syn_val),
    .syn_min(syn_min), .syn_max(syn_max),
    .bit_vld(bit_vld), .bit_pos(bit_pos), .sc_pos(sc_pos),
    .slice_end(slice_end), .trail_ok(trail_ok),
    .frm_vld(frm_vld), .frm_num(frm_num),
    .hit(hit)
  );

  vdec_err_sevmap u_sevmap (.hit(hit), .cfg(chk_sev), .top_sev(hit_sev));

  vdec_err_flags u_flags (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(flag_clr),
    .flags(err_flags), .irq(err_irq)
  );

  vdec_err_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hit_sev(hit_sev), .ack(fw_ack),
    .cmd(pipe_cmd), .sev(err_sev)
  );

  // R6: a disabled check never raises its flag
  a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(err_flags) & ~$past(chk_en) & err_flags) == '0));
  // R8: no error in a cycle reports severity 0 next cycle
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> (err_sev == 2'd0));
endmodule

// File: tb/vdec_err_dispatch_bench.sv
module vdec_err_dispatch_bench;
  typedef struct {
    logic [5:0]         en;
    logic [11:0]        sv;
    logic               cv;
    logic [6:0]         cc;
    logic               yv, mv;
    logic signed [15:0] val, mn, mx;
    logic               bv;
    logic [23:0]        bp, sp;
    logic               se, to;
    logic               fv;
    logic [7:0]         fn;
    logic [5:0]         clr;
    logic               ack;
  } stim_t;

  typedef struct {
    logic [5:0] fl;
    logic       irq;
    logic [1:0] sev, cmd;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [5:0] chk_en, flag_clr, err_flags;
  logic [11:0] chk_sev;
  logic coef_vld, syn_vld, syn_is_mv, bit_vld, slice_end, trail_ok, frm_vld, fw_ack, err_irq;
  logic [6:0] coef_cnt;
  logic signed [15:0] syn_val, syn_min, syn_max;
  logic [23:0] bit_pos, sc_pos;
  logic [7:0] frm_num;
  logic [1:0] err_sev, pipe_cmd;

  vdec_err_dispatch u_vdec_err_dispatch (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .chk_sev(chk_sev),
    .coef_vld(coef_vld), .coef_cnt(coef_cnt), .syn_vld(syn_vld), .syn_is_mv(syn_is_mv),
    .syn_val(syn_val), .syn_min(syn_min), .syn_max(syn_max), .bit_vld(bit_vld),
    .bit_pos(bit_pos), .sc_pos(sc_pos), .slice_end(slice_end), .trail_ok(trail_ok),
    .frm_vld(frm_vld), .frm_num(frm_num), .flag_clr(flag_clr), .fw_ack(fw_ack),
    .err_flags(err_flags), .err_irq(err_irq), .err_sev(err_sev), .pipe_cmd(pipe_cmd)
  );

  int nvec = 0, nerr = 0;
  exp_t  q[$];
  string tq[$];

  logic [5:0]  m_flags = '0;
  logic [1:0]  m_cmd = '0;
  logic [7:0]  m_prev = '0;
  logic        m_seen = 1'b0;
  logic [11:0] cur_sev = '0;

  function automatic stim_t nop();
    stim_t s;
    s.en = 6'h3F; s.sv = cur_sev;
    s.cv = 0; s.cc = 0; s.yv = 0; s.mv = 0; s.val = 0; s.mn = 0; s.mx = 0;
    s.bv = 0; s.bp = 0; s.sp = 0; s.se = 0; s.to = 1; s.fv = 0; s.fn = 0;
    s.clr = 0; s.ack = 0;
    return s;
  endfunction

  function automatic logic [1:0] lvl(input logic [1:0] c);
    return (c == 2'd0) ? 2'd1 : c;
  endfunction

  task automatic apply(input stim_t s, input string tag);
    logic [5:0] h;
    logic [1:0] hs, base;
    logic       oor;
    exp_t e;
    @(negedge clk);
    chk_en = s.en; chk_sev = s.sv; coef_vld = s.cv; coef_cnt = s.cc;
    syn_vld = s.yv; syn_is_mv = s.mv; syn_val = s.val; syn_min = s.mn; syn_max = s.mx;
    bit_vld = s.bv; bit_pos = s.bp; sc_pos = s.sp; slice_end = s.se; trail_ok = s.to;
    frm_vld = s.fv; frm_num = s.fn; flag_clr = s.clr; fw_ack = s.ack;
    oor = (s.val < s.mn) || (s.val > s.mx);
    h = '0;
    h[0] = s.cv && (s.cc > 7'd64);
    h[1] = s.bv && (s.bp > s.sp);
    h[2] = s.yv && !s.mv && oor;
    h[3] = s.yv && s.mv && oor;
    h[4] = s.se && !s.to;
    h[5] = s.fv && m_seen && (s.fn != m_prev + 8'd1);
    if (s.fv) begin m_prev = s.fn; m_seen = 1'b1; end
    h = h & s.en;
    hs = 2'd0;
    for (int i = 0; i < 6; i++)
      if (h[i] && lvl(s.sv[2*i +: 2]) > hs) hs = lvl(s.sv[2*i +: 2]);
    m_flags = (m_flags & ~s.clr) | h;
    base = (m_cmd >= 2'd2 && !s.ack) ? m_cmd : 2'd0;
    m_cmd = (hs > base) ? hs : base;
    e.fl = m_flags; e.irq = |m_flags; e.sev = hs; e.cmd = m_cmd;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      nvec++;
      if (err_flags !== e.fl || err_irq !== e.irq || err_sev !== e.sev || pipe_cmd !== e.cmd) begin
        nerr++;
        $display("FAIL %s: got flags=%h irq=%b sev=%0d cmd=%0d, expected flags=%h irq=%b sev=%0d cmd=%0d",
                 t, err_flags, err_irq, err_sev, pipe_cmd, e.fl, e.irq, e.sev, e.cmd);
      end
    end
  end

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    stim_t s;
    s = nop();
    chk_en = s.en; chk_sev = s.sv; coef_vld = 0; coef_cnt = 0; syn_vld = 0; syn_is_mv = 0;
    syn_val = 0; syn_min = 0; syn_max = 0; bit_vld = 0; bit_pos = 0; sc_pos = 0;
    slice_end = 0; trail_ok = 1; frm_vld = 0; frm_num = 0; flag_clr = 0; fw_ack = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nvec++;
    if (err_flags !== 0 || err_irq !== 0 || err_sev !== 0 || pipe_cmd !== 0) begin
      nerr++;
      $display("FAIL reset R7/R9: got flags=%h irq=%b sev=%0d cmd=%0d, expected all 0",
               err_flags, err_irq, err_sev, pipe_cmd);
    end

    apply(nop(), "R9 idle run");
    // R1 boundary, severity code 0 treated as 1 (R8)
    s = nop(); s.cv = 1; s.cc = 7'd64; apply(s, "R1 count 64");
    s = nop(); s.cv = 1; s.cc = 7'd65; apply(s, "R1 count 65 / R8 code0");
    apply(nop(), "R9 subst one cycle");
    s = nop(); s.cv = 1; s.cc = 7'd100; s.clr = 6'h01; apply(s, "R7 set wins over clear");
    s = nop(); s.clr = 6'h01; apply(s, "R7 clear");
    // R2
    s = nop(); s.bv = 1; s.bp = 24'd500; s.sp = 24'd500; apply(s, "R2 equal");
    s = nop(); s.bv = 1; s.bp = 24'd501; s.sp = 24'd500; apply(s, "R2 beyond");
    // R3
    s = nop(); s.yv = 1; s.val = -16'sd5; s.mn = -16'sd4; s.mx = 16'sd10; apply(s, "R3 syntax low");
    s = nop(); s.yv = 1; s.val = 16'sd10; s.mn = -16'sd4; s.mx = 16'sd10; apply(s, "R3 syntax at max");
    s = nop(); s.yv = 1; s.mv = 1; s.val = 16'sd11; s.mn = -16'sd4; s.mx = 16'sd10; apply(s, "R3 mv high");
    s = nop(); s.yv = 1; s.mv = 1; s.val = -16'sd4; s.mn = -16'sd4; s.mx = 16'sd10; apply(s, "R3 mv at min");
    // R4
    s = nop(); s.se = 1; s.to = 1; apply(s, "R4 trailing good");
    s = nop(); s.se = 1; s.to = 0; apply(s, "R4 trailing bad");
    // R5
    s = nop(); s.fv = 1; s.fn = 8'd7; apply(s, "R5 first frame");
    s = nop(); s.fv = 1; s.fn = 8'd8; apply(s, "R5 in order");
    s = nop(); s.fv = 1; s.fn = 8'd10; apply(s, "R5 gap");
    s = nop(); s.fv = 1; s.fn = 8'd255; apply(s, "R5 jump");
    s = nop(); s.fv = 1; s.fn = 8'd0; apply(s, "R5 wrap");
    s = nop(); s.clr = 6'h3F; apply(s, "R7 clear all");
    // R6
    s = nop(); s.en = 6'h3E; s.cv = 1; s.cc = 7'd90; apply(s, "R6 disabled coef");
    s = nop(); s.en = 6'h2F; s.se = 1; s.to = 0; s.bv = 1; s.bp = 24'd9; s.sp = 24'd1; apply(s, "R6 trail off, overrun on");
    s = nop(); s.clr = 6'h3F; apply(s, "R7 clear all");
    // R10 with severities: coef=2, syn=1, trail=3, frame gap=3
    cur_sev = {2'd3, 2'd3, 2'd1, 2'd1, 2'd1, 2'd2};
    s = nop(); s.cv = 1; s.cc = 7'd70; apply(s, "R10 stop slice");
    apply(nop(), "R10 held 1");
    apply(nop(), "R10 held 2");
    s = nop(); s.ack = 1; apply(s, "R10 ack release");
    s = nop(); s.cv = 1; s.cc = 7'd70; apply(s, "R10 stop again");
    s = nop(); s.se = 1; s.to = 0; apply(s, "R10 upgrade to 3");
    s = nop(); s.yv = 1; s.val = 16'sd50; s.mn = 0; s.mx = 16'sd1; apply(s, "R10 no downgrade / R8 sev1");
    s = nop(); s.ack = 1; s.cv = 1; s.cc = 7'd99; apply(s, "R10 ack with new stop");
    s = nop(); s.ack = 1; apply(s, "R10 ack");
    // R9 highest severity wins
    s = nop(); s.cv = 1; s.cc = 7'd80; s.se = 1; s.to = 0; s.yv = 1; s.val = -16'sd9; s.mn = 0; s.mx = 16'sd3;
    apply(s, "R9 mixed severities");
    s = nop(); s.ack = 1; apply(s, "R10 ack mixed");
    // R11
    s = nop(); s.yv = 1; s.val = 16'sd9; s.mn = 0; s.mx = 16'sd3; apply(s, "R11 subst");
    s = nop(); s.ack = 1; apply(s, "R11 ack while not held");
    s = nop(); s.ack = 1; apply(s, "R11 ack at run");
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule